// File: doc/BRIEF.md
# Signed-Magnitude Sequential Shift-Add Multiplier

This block multiplies two signed-magnitude integers over several clock cycles. Each operand arrives as a sign bit and an unsigned magnitude of `MAG_W` bits. When a start request is accepted, the block takes a copy of both magnitudes and both signs and clears an accumulator. It then runs one step per clock for `MAG_W` clocks. Each step adds the multiplicand into the accumulator if the multiplier's low bit is set, and otherwise adds nothing. In the same clock it shifts the carry, accumulator and multiplier chain right by one place. When the step count runs out, the block raises `done` for one cycle. The double-length magnitude and the product sign are then available until the next accepted start.

The sign path is separate from the magnitude path. The product sign is the exclusive-or of the two operand signs. It is applied even when the magnitude is zero, so the block can return a negative zero. A surrounding datapath issues a start pulse with the operands, waits on `busy`/`done` and then picks up `prodMag` and `prodSign`.

Top module: `smag_mul`

## Requirements
- R1: While reset (`rstN` low) is asserted, and in the first cycle after it, `busy`, `done`, `prodSign` and every bit of `prodMag` are 0.
- R2: A start request is accepted at a rising edge where `start` is 1 and `busy` is 0. After that edge, `busy` is 1.
- R3: Suppose a request is accepted at edge k. Then `busy` stays 1 after edges k through k+MAG_W-1 and falls after edge k+MAG_W. That is exactly one step per magnitude bit, with the add and the shift fused into one clock.
- R4: `done` is 1 only in the single cycle after edge k+MAG_W, and `busy` is 0 in that cycle.
- R5: When `done` is 1, `prodMag` equals the unsigned product of the two magnitudes sampled at the accepting edge. The high half of `prodMag` comes from the accumulator and the low half from the multiplier register. This includes the all-ones by all-ones case.
- R6: When `done` is 1, `prodSign` equals the exclusive-or of the two sampled signs, with no adjustment for a zero magnitude.
- R7: While `busy` is 1, neither `start` nor changes on any operand input has an effect: the timing and the result stay those of the accepted request.
- R8: While `busy` is 0 and no request is accepted, `prodMag` and `prodSign` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; taken only when idle |
| mcandSign | input | 1 | Multiplicand sign, 1 = negative |
| mcandMag | input | MAG_W | Multiplicand magnitude |
| mplierSign | input | 1 | Multiplier sign, 1 = negative |
| mplierMag | input | MAG_W | Multiplier magnitude |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: result is ready |
| prodSign | output | 1 | Product sign |
| prodMag | output | 2*MAG_W | Product magnitude |

## Verification
The checker assumes only that operands are valid at the edge where a request is accepted. It captures them there itself, so it places no constraint on the operand inputs while the block is busy. The bench takes advantage of that freedom: during every operation it scrambles all four operand inputs and pulses `start`, and it also holds `start` high across back-to-back operations. Operands cover zero, one and all-ones magnitudes, all four sign combinations, and random values.

// File: rtl/smag_mul_pkg.sv
package smag_mul_pkg;

  // Strobes issued by the control to the datapath each clock
  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // conditional add plus right shift
  } smStrobe_t;

endpackage

// File: rtl/smag_mul_ctrl.sv
module smag_mul_ctrl
  import smag_mul_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output smStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = $clog2(MAG_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MAG_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] stepsLeft;
  logic             busyReg;
  logic             doneReg;

  always_comb begin
    strobe.load = start && !busyReg;
    strobe.step = busyReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepsLeft <= '0;
      busyReg   <= 1'b0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (strobe.load) begin
        stepsLeft <= CNT_LOAD;
        busyReg   <= 1'b1;
      end else if (strobe.step) begin
        stepsLeft <= stepsLeft - CNT_ONE;
        if (stepsLeft == CNT_ONE) begin
          busyReg <= 1'b0;
          doneReg <= 1'b1;
        end
      end
    end
  end

  assign busy = busyReg;
  assign done = doneReg;

endmodule

// File: rtl/smag_mul_dp.sv
module smag_mul_dp
  import smag_mul_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  smStrobe_t          strobe,
  input  logic               mcandSign,
  input  logic [MAG_W-1:0]   mcandMag,
  input  logic               mplierSign,
  input  logic [MAG_W-1:0]   mplierMag,
  output logic               prodSign,
  output logic [2*MAG_W-1:0] prodMag
);

  logic [MAG_W-1:0] mReg;     // multiplicand magnitude
  logic [MAG_W-1:0] qReg;     // multiplier magnitude, fills with low product bits
  logic [MAG_W-1:0] accReg;   // high half of partial product
  logic             mSignReg;
  logic             qSignReg;

  logic [MAG_W-1:0] addend;
  logic [MAG_W:0]   sumWide;  // carry plus accumulator after the add

  // Addend is the multiplicand gated by the current multiplier bit
  for (genvar i = 0; i < MAG_W; i++) begin : g_gate
    assign addend[i] = mReg[i] & qReg[0];
  end

  always_comb begin
    sumWide = {1'b0, accReg} + {1'b0, addend};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg     <= '0;
      qReg     <= '0;
      accReg   <= '0;
      mSignReg <= 1'b0;
      qSignReg <= 1'b0;
    end else if (strobe.load) begin
      mReg     <= mcandMag;
      qReg     <= mplierMag;
      accReg   <= '0;
      mSignReg <= mcandSign;
      qSignReg <= mplierSign;
    end else if (strobe.step) begin
      // shift carry:acc:q right by one place
      accReg <= sumWide[MAG_W:1];
      qReg   <= {sumWide[0], qReg[MAG_W-1:1]};
    end
  end

  assign prodMag  = {accReg, qReg};
  assign prodSign = mSignReg ^ qSignReg;

endmodule

// File: rtl/smag_mul.sv
module smag_mul
  import smag_mul_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               mcandSign,
  input  logic [MAG_W-1:0]   mcandMag,
  input  logic               mplierSign,
  input  logic [MAG_W-1:0]   mplierMag,
  output logic               busy,
  output logic               done,
  output logic               prodSign,
  output logic [2*MAG_W-1:0] prodMag
);

  smStrobe_t strobe;

  smag_mul_ctrl #(.MAG_W(MAG_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  smag_mul_dp #(.MAG_W(MAG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .mcandSign  (mcandSign),
    .mcandMag   (mcandMag),
    .mplierSign (mplierSign),
    .mplierMag  (mplierMag),
    .prodSign   (prodSign),
    .prodMag    (prodMag)
  );

endmodule

// File: rtl/smag_mul_chk.sv
module smag_mul_chk #(
  parameter int MAG_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               mcandSign,
  input logic [MAG_W-1:0]   mcandMag,
  input logic               mplierSign,
  input logic [MAG_W-1:0]   mplierMag,
  input logic               busy,
  input logic               done,
  input logic               prodSign,
  input logic [2*MAG_W-1:0] prodMag
);

  localparam int CNT_W = $clog2(MAG_W + 1);

  logic               accept;
  logic [MAG_W-1:0]   capM;
  logic [MAG_W-1:0]   capQ;
  logic               capSign;
  logic [CNT_W:0]     busyCyc;
  logic [2*MAG_W-1:0] expProd;

  assign accept  = start && !busy;
  assign expProd = {{MAG_W{1'b0}}, capM} * {{MAG_W{1'b0}}, capQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capM    <= '0;
      capQ    <= '0;
      capSign <= 1'b0;
      busyCyc <= '0;
    end else if (accept) begin
      capM    <= mcandMag;
      capQ    <= mplierMag;
      capSign <= mcandSign ^ mplierSign;
      busyCyc <= '0;
    end else if (busy) begin
      busyCyc <= busyCyc + 1'b1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN) accept |=> busy); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN) done |-> (busyCyc == (CNT_W+1)'(MAG_W))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R4
  AST_PRODUCT: assert property (@(posedge clk) disable iff (!rstN) done |-> (prodMag == expProd)); // R5
  AST_SIGN: assert property (@(posedge clk) disable iff (!rstN) done |-> (prodSign == capSign)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (busy && start) |=> (busy || done)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN) (!busy && !start) |=> ($stable(prodMag) && $stable(prodSign))); // R8

endmodule

bind smag_mul smag_mul_chk #(.MAG_W(MAG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .mcandSign  (mcandSign),
  .mcandMag   (mcandMag),
  .mplierSign (mplierSign),
  .mplierMag  (mplierMag),
  .busy       (busy),
  .done       (done),
  .prodSign   (prodSign),
  .prodMag    (prodMag)
);

// File: tb/smag_mul_tb.sv
`timescale 1ns/1ps
module smag_mul_tb;

  localparam int MAG_W = 8;
  localparam int PW    = 2 * MAG_W;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic           mcandSign = 1'b0;
  logic [MAG_W-1:0] mcandMag = '0;
  logic           mplierSign = 1'b0;
  logic [MAG_W-1:0] mplierMag = '0;
  logic           busy;
  logic           done;
  logic           prodSign;
  logic [PW-1:0]  prodMag;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  smag_mul #(.MAG_W(MAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .mcandSign(mcandSign), .mcandMag(mcandMag),
    .mplierSign(mplierSign), .mplierMag(mplierMag),
    .busy(busy), .done(done), .prodSign(prodSign), .prodMag(prodMag)
  );

  // Behavioural reference, updated on each rising edge
  bit            mBusy = 0;
  bit            mDone = 0;
  int            mLeft = 0;
  logic [PW-1:0] mProd = '0;
  bit            mSign = 0;
  logic [PW-1:0] pendProd = '0;
  bit            pendSign = 0;
  bit            modelOn = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mLeft = 0; mProd = '0; mSign = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin
          mBusy = 0; mDone = 1; mProd = pendProd; mSign = pendSign;
        end
      end else if (start) begin
        mBusy = 1;
        mLeft = MAG_W;
        pendProd = PW'(mcandMag) * PW'(mplierMag);
        pendSign = mcandSign ^ mplierSign;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (modelOn) begin
      chk(busy == mBusy, "R2/R3 busy", PW'(busy), PW'(mBusy));
      chk(done == mDone, "R4 done", PW'(done), PW'(mDone));
      if (!mBusy) begin
        chk(prodMag == mProd, "R5/R8 prodMag", prodMag, mProd);
        chk(prodSign == mSign, "R6/R8 prodSign", PW'(prodSign), PW'(mSign));
      end
    end
  end

  task automatic scramble();
    mcandSign  = 1'($urandom);
    mplierSign = 1'($urandom);
    mcandMag   = MAG_W'($urandom);
    mplierMag  = MAG_W'($urandom);
  endtask

  // One operation; R7: operands scrambled and start pulsed while busy
  task automatic runOp(input bit ms, input logic [MAG_W-1:0] mm,
                       input bit qs, input logic [MAG_W-1:0] qm, input bit noisy);
    @(negedge clk);
    mcandSign = ms; mcandMag = mm; mplierSign = qs; mplierMag = qm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < MAG_W + 2; i++) begin
      if (noisy && busy) begin
        scramble();
        start = 1'($urandom);
      end else begin
        start = 1'b0;
      end
      if (done) break;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done, "R1 ctrl in reset", PW'({busy, done}), '0);
    chk(prodMag == '0 && !prodSign, "R1 result in reset", prodMag, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && prodMag == '0 && !prodSign, "R1 after reset", prodMag, '0);
    modelOn = 1;

    runOp(0, 8'd13, 0, 8'd11, 0);
    runOp(1, 8'd200, 0, 8'd3, 0);
    runOp(0, 8'd255, 1, 8'd255, 0);      // R5 extreme magnitudes
    runOp(1, 8'd255, 1, 8'd1, 0);
    runOp(1, 8'd0, 0, 8'd77, 0);         // R6 negative zero
    runOp(0, 8'd77, 1, 8'd0, 1);
    runOp(1, 8'd128, 1, 8'd129, 1);      // R7 noisy
    runOp(0, 8'd1, 0, 8'd1, 1);

    // R7 back-to-back with start held high
    @(negedge clk);
    mcandMag = 8'd99; mplierMag = 8'd201; mcandSign = 1; mplierSign = 0;
    start = 1'b1;
    repeat (3 * (MAG_W + 1) + 1) @(negedge clk);
    start = 1'b0;
    repeat (MAG_W + 3) @(negedge clk);

    // R8 idle hold while operands change
    for (int i = 0; i < 6; i++) begin
      scramble();
      @(negedge clk);
    end

    for (int n = 0; n < 300; n++) begin
      runOp(1'($urandom), MAG_W'($urandom), 1'($urandom), MAG_W'($urandom), n[0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule